// File: doc/BRIEF.md
# Wake-up Event Flag Capture

This block keeps three sticky wake-up flags for an auxiliary power domain. Single-cycle pulses arriving from the always-on side set the flags: one flag for a real-time-counter compare event, one for a software-triggered event and one for a programmable wake-up that is fed by up to three configurable source slots. Software reads the flags through a read-only register word. It clears them through a separate clear register.

Clearing follows a level protocol. Software writes 1 to a clear bit and keeps that bit at 1 until the flag reads back 0. It then writes the bit back to 0. The flag drops two cycles after its clear bit is set, which models the delay of the domain crossing. The programmable flag can only be cleared when one of its slots selects an I/O event whose pin is ready for the auxiliary domain. When a slot selects the compare event, clearing the compare flag also clears the programmable flag.

Top module: `wuf_capture`

## Requirements
- R1: After a synchronous reset, the flag word (address 0) and the clear word (address 1) both read 0.
- R2: A pulse on `rtc_cmp_evt` sets flag bit 2 in the next cycle, whatever the slot kinds are.
- R3: A pulse on `sw_evt` sets flag bit 1 in the next cycle.
- R4: Flag bit 0 is set in the next cycle when a slot produces an event. A slot of kind 2'b01 (I/O) or 2'b11 (other) takes its event from its `slot_evt` bit. A slot of kind 2'b10 (compare) takes its event from `rtc_cmp_evt`. A slot of kind 2'b00 (none) never sets the flag. Slot i uses `slot_kind[2i+1:2i]`.
- R5: A write to address 0 has no effect. At address 1, bits 2:0 are writable and read back, and bits 31:3 read 0. Any other address reads 0.
- R6: Once an effective clear bit is set, its flag reads 0 from two cycles after the write, and not earlier.
- R7: An event arriving while its effective clear bit is 1, or in the cycle after that bit returns to 0, is discarded.
- R8: Clear bit 0 takes effect only while some slot has kind I/O with its `slot_io_ready` bit at 1. Otherwise it leaves flag bit 0 unchanged.
- R9: Clear bit 2 also clears flag bit 0 when some slot has kind compare. Otherwise flag bit 0 is unaffected by clear bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (2) | Word index: 0 is the flag word, 1 is the clear word |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| rtc_cmp_evt | input | 1 | Compare event pulse |
| sw_evt | input | 1 | Software event pulse |
| slot_evt | input | NSLOT (3) | Event pulse for each programmable slot |
| slot_kind | input | 2*NSLOT (6) | Packed source kind for each slot |
| slot_io_ready | input | NSLOT (3) | Per slot: the I/O pin is assigned to the domain with its input enabled |

## Verification
The flags are set from each source in turn. Slots of kind none carry pulses that must be ignored, and a compare slot must route the compare pulse into the programmable flag. This separates the source decoding from the plain event paths. Clear is tried in three programmable-source settings: no I/O slot, an I/O slot that is not ready, and a ready I/O slot. These show that the clear is gated on the slot state while the clear bit is held. The compare clear is applied both with and without a compare slot, which shows that the cross-clear depends on the slot selection. An event pulse that arrives while a clear is held shows that the event is discarded rather than deferred.

// File: rtl/wuf_pkg.sv
package wuf_pkg;

    localparam int FLAG_N   = 3;
    localparam int KIND_W   = 2;
    localparam int FLAG_IDX = 0;
    localparam int CLR_IDX  = 1;

    typedef enum logic [KIND_W-1:0] {
        SRC_NONE  = 2'b00,
        SRC_IO    = 2'b01,
        SRC_RTC   = 2'b10,
        SRC_OTHER = 2'b11
    } src_kind_t;

    // bit 2 compare, bit 1 software, bit 0 programmable
    typedef struct packed {
        logic rtc;
        logic sw;
        logic prog;
    } flag_vec_t;

    function automatic logic slot_fires(src_kind_t k, logic own_evt, logic rtc_evt);
        case (k)
            SRC_IO, SRC_OTHER: return own_evt;
            SRC_RTC:           return rtc_evt;
            default:           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wuf_src_decode.sv
module wuf_src_decode
    import wuf_pkg::*;
#(
    parameter int NSLOT = 3
) (
    input  logic                    rtc_cmp_evt,
    input  logic [NSLOT-1:0]        slot_evt,
    input  logic [KIND_W*NSLOT-1:0] slot_kind,
    input  logic [NSLOT-1:0]        slot_io_ready,
    output logic                    prog_hit,
    output logic                    io_clr_ok,
    output logic                    rtc_in_prog
);

    logic [NSLOT-1:0] hit_v;
    logic [NSLOT-1:0] io_v;
    logic [NSLOT-1:0] rtc_v;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        src_kind_t kind;
        assign kind     = src_kind_t'(slot_kind[KIND_W*i +: KIND_W]);
        assign hit_v[i] = slot_fires(kind, slot_evt[i], rtc_cmp_evt);
        assign io_v[i]  = (kind == SRC_IO) && slot_io_ready[i];
        assign rtc_v[i] = (kind == SRC_RTC);
    end

    assign prog_hit    = |hit_v;
    assign io_clr_ok   = |io_v;
    assign rtc_in_prog = |rtc_v;

endmodule

// File: rtl/wuf_clr_ctrl.sv
module wuf_clr_ctrl
    import wuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_clr,
    input  logic [FLAG_N-1:0] wdata,
    input  logic             io_clr_ok,
    input  logic             rtc_in_prog,
    output flag_vec_t        clr_q,
    output flag_vec_t        clr_eff,
    output flag_vec_t        clr_dly
);

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q <= '0;
        end else if (wr_clr) begin
            clr_q <= flag_vec_t'(wdata);
        end
    end

    always_comb begin
        clr_eff.rtc  = clr_q.rtc;
        clr_eff.sw   = clr_q.sw;
        clr_eff.prog = (clr_q.prog & io_clr_ok) | (clr_q.rtc & rtc_in_prog);
    end

    // one crossing stage: flag clears two cycles after the write
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_dly <= '0;
        end else begin
            clr_dly <= clr_eff;
        end
    end

endmodule

// File: rtl/wuf_flag_bank.sv
module wuf_flag_bank
    import wuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_in,
    input  flag_vec_t clr_eff,
    input  flag_vec_t clr_dly,
    output flag_vec_t flags
);

    logic [FLAG_N-1:0] set_b, eff_b, dly_b, flg_b;

    assign set_b = set_in;
    assign eff_b = clr_eff;
    assign dly_b = clr_dly;
    assign flags = flag_vec_t'(flg_b);

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flg_b[i] <= 1'b0;
            end else if (dly_b[i]) begin
                flg_b[i] <= 1'b0;
            end else if (set_b[i] && !eff_b[i]) begin
                flg_b[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wuf_capture.sv
module wuf_capture
    import wuf_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic                    rtc_cmp_evt,
    input  logic                    sw_evt,
    input  logic [NSLOT-1:0]        slot_evt,
    input  logic [KIND_W*NSLOT-1:0] slot_kind,
    input  logic [NSLOT-1:0]        slot_io_ready
);

    localparam int PAD_W = DATA_W - FLAG_N;

    logic      prog_hit, io_clr_ok, rtc_in_prog;
    flag_vec_t set_vec, clr_q, clr_eff, clr_dly, flags_q;
    logic      wr_clr;
    logic      unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:FLAG_N];

    wuf_src_decode #(.NSLOT(NSLOT)) u_dec (
        .rtc_cmp_evt  (rtc_cmp_evt),
        .slot_evt     (slot_evt),
        .slot_kind    (slot_kind),
        .slot_io_ready(slot_io_ready),
        .prog_hit     (prog_hit),
        .io_clr_ok    (io_clr_ok),
        .rtc_in_prog  (rtc_in_prog)
    );

    assign wr_clr = reg_wr && (reg_addr == ADDR_W'(CLR_IDX));

    wuf_clr_ctrl u_clr (
        .clk        (clk),
        .rst        (rst),
        .wr_clr     (wr_clr),
        .wdata      (reg_wdata[FLAG_N-1:0]),
        .io_clr_ok  (io_clr_ok),
        .rtc_in_prog(rtc_in_prog),
        .clr_q      (clr_q),
        .clr_eff    (clr_eff),
        .clr_dly    (clr_dly)
    );

    always_comb begin
        set_vec.rtc  = rtc_cmp_evt;
        set_vec.sw   = sw_evt;
        set_vec.prog = prog_hit;
    end

    wuf_flag_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_in (set_vec),
        .clr_eff(clr_eff),
        .clr_dly(clr_dly),
        .flags  (flags_q)
    );

    always_comb begin
        if (reg_addr == ADDR_W'(FLAG_IDX)) begin
            reg_rdata = {{PAD_W{1'b0}}, flags_q};
        end else if (reg_addr == ADDR_W'(CLR_IDX)) begin
            reg_rdata = {{PAD_W{1'b0}}, clr_q};
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/wuf_capture_chk.sv
module wuf_capture_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] flags,
    input logic [2:0] clr_q,
    input logic [2:0] clr_dly,
    input logic       rtc_evt,
    input logic       sw_evt,
    input logic       rtc_in_prog
);

    // R2
    rtc_set_chk: assert property (@(posedge clk) disable iff (rst)
        rtc_evt && !clr_q[2] && !clr_dly[2] |=> flags[2]);

    // R3
    sw_set_chk: assert property (@(posedge clk) disable iff (rst)
        sw_evt && !clr_q[1] && !clr_dly[1] |=> flags[1]);

    // R6
    clr_lat_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr_q[1], 2) && $past(clr_q[1]) |-> !flags[1]);

    // R7
    held_block_chk: assert property (@(posedge clk) disable iff (rst)
        clr_q[1] |=> !$rose(flags[1]));

    // R9
    cross_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr_q[2], 2) && $past(rtc_in_prog, 2) && $past(clr_q[2]) |-> !flags[0]);

endmodule

bind wuf_capture wuf_capture_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .flags      (flags_q),
    .clr_q      (clr_q),
    .clr_dly    (clr_dly),
    .rtc_evt    (rtc_cmp_evt),
    .sw_evt     (sw_evt),
    .rtc_in_prog(rtc_in_prog)
);

// File: tb/wuf_capture_test.sv
module wuf_capture_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rtc_cmp_evt = 1'b0;
    logic        sw_evt = 1'b0;
    logic [2:0]  slot_evt = '0;
    logic [5:0]  slot_kind = '0;
    logic [2:0]  slot_io_ready = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wuf_capture uut (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .rtc_cmp_evt  (rtc_cmp_evt),
        .sw_evt       (sw_evt),
        .slot_evt     (slot_evt),
        .slot_kind    (slot_kind),
        .slot_io_ready(slot_io_ready)
    );

    task automatic expect_rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic r, input logic s, input logic [2:0] p);
        @(negedge clk);
        rtc_cmp_evt = r; sw_evt = s; slot_evt = p;
        @(negedge clk);
        rtc_cmp_evt = 1'b0; sw_evt = 1'b0; slot_evt = '0;
    endtask

    task automatic clear_release(input logic [2:0] m);
        wr(2'd1, {29'd0, m});
        repeat (3) @(negedge clk);
        wr(2'd1, 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        expect_rd(2'd0, 32'd0, "R1 flags");
        expect_rd(2'd1, 32'd0, "R1 clear");
    endtask

    task automatic t_rtc_sw;
        slot_kind = '0;
        pulse(1'b1, 1'b0, 3'b000);
        expect_rd(2'd0, 32'd4, "R2 compare flag");
        pulse(1'b0, 1'b1, 3'b000);
        expect_rd(2'd0, 32'd6, "R3 software flag");
    endtask

    task automatic t_clear;
        wr(2'd1, 32'd6);
        expect_rd(2'd1, 32'd6, "R5 clear readback");
        expect_rd(2'd0, 32'd6, "R6 no early clear");
        @(negedge clk);
        expect_rd(2'd0, 32'd6, "R6 one cycle");
        @(negedge clk);
        expect_rd(2'd0, 32'd0, "R6 cleared");
        pulse(1'b0, 1'b1, 3'b000);
        expect_rd(2'd0, 32'd0, "R7 event discarded while held");
        wr(2'd1, 32'd0);
        repeat (2) @(negedge clk);
        pulse(1'b0, 1'b1, 3'b000);
        expect_rd(2'd0, 32'd2, "R3 set after release");
        clear_release(3'b010);
        expect_rd(2'd0, 32'd0, "R6 software cleared");
    endtask

    task automatic t_prog;
        slot_kind = '0; slot_io_ready = '0;
        pulse(1'b0, 1'b0, 3'b111);
        expect_rd(2'd0, 32'd0, "R4 none kind ignored");
        slot_kind[1:0] = 2'b11;
        pulse(1'b0, 1'b0, 3'b001);
        expect_rd(2'd0, 32'd1, "R4 other kind sets");
        slot_kind[5:4] = 2'b01; slot_io_ready[2] = 1'b1;
        clear_release(3'b001);
        expect_rd(2'd0, 32'd0, "R8 ready I/O slot clears");
        slot_kind[3:2] = 2'b10;
        pulse(1'b1, 1'b0, 3'b000);
        expect_rd(2'd0, 32'd5, "R4 compare slot sets");
        clear_release(3'b100);
        expect_rd(2'd0, 32'd0, "R9 cross clear");
    endtask

    task automatic t_prog_blocked;
        slot_kind = 6'b00_00_11; slot_io_ready = '0;
        pulse(1'b0, 1'b0, 3'b001);
        expect_rd(2'd0, 32'd1, "R4 set before blocked clear");
        wr(2'd1, 32'd1);
        repeat (4) @(negedge clk);
        expect_rd(2'd0, 32'd1, "R8 no I/O slot");
        slot_kind[3:2] = 2'b01;
        repeat (3) @(negedge clk);
        expect_rd(2'd0, 32'd1, "R8 I/O slot not ready");
        slot_io_ready[1] = 1'b1;
        @(negedge clk);
        expect_rd(2'd0, 32'd1, "R8 ready one cycle");
        @(negedge clk);
        expect_rd(2'd0, 32'd0, "R8 ready clears");
        wr(2'd1, 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_cross_neg;
        slot_kind = 6'b00_00_11; slot_io_ready = '0;
        pulse(1'b1, 1'b0, 3'b000);
        expect_rd(2'd0, 32'd4, "R2 no compare slot");
        pulse(1'b0, 1'b0, 3'b001);
        expect_rd(2'd0, 32'd5, "R4 other slot");
        clear_release(3'b100);
        expect_rd(2'd0, 32'd1, "R9 no cross clear");
        slot_kind[1:0] = 2'b01; slot_io_ready[0] = 1'b1;
        clear_release(3'b001);
        expect_rd(2'd0, 32'd0, "R8 cleanup");
    endtask

    task automatic t_reg_access;
        pulse(1'b0, 1'b1, 3'b000);
        wr(2'd0, 32'd0);
        expect_rd(2'd0, 32'd2, "R5 flag write ignored zero");
        wr(2'd0, 32'hFFFF_FFFF);
        expect_rd(2'd0, 32'd2, "R5 flag write ignored ones");
        wr(2'd1, 32'hFFFF_FFF8);
        expect_rd(2'd1, 32'd0, "R5 upper clear bits read 0");
        expect_rd(2'd2, 32'd0, "R5 unused address");
        expect_rd(2'd3, 32'd0, "R5 unused address");
        expect_rd(2'd0, 32'd2, "R5 flags kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rtc_sw();
        t_clear();
        t_prog();
        t_prog_blocked();
        t_cross_neg();
        t_reg_access();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule